// File: doc/BRIEF.md
# Wide-to-Narrow Write Burst Downsizer

This block sits between a 128-bit write-only slave port and a 64-bit master port, and carries the write address, write data and write response channels. Each upstream transaction is decoded once, when its address is accepted. From its beat size, cacheability, alignment and length, the block picks one of three ways to move the data. It then issues one or more downstream bursts and returns exactly one response upstream.

There are three paths. Beats of 8 bytes or more are expanded: each input beat becomes two output beats, lower half first. Beats of exactly 4 bytes are merged two-to-one into full 64-bit beats when the transaction allows it. Any other beat is passed through one-for-one, folded onto the half of the bus that carries its bytes.

An expanded transaction may need more than 256 output beats. In that case it is cut into several downstream bursts, its exclusive-access marking is cleared, and the downstream responses are combined by error severity. The block handles one transaction at a time. The end of the input data is set by the accepted length, so the input port has no separate last flag.

Top module: `dsz_top`

## Requirements
- R1: After reset, the block accepts a new address (`sAwReady` = 1), and `mAwValid`, `mWValid` and `sBValid` are all 0.
- R2: When the size code is 3 or more (8 or 16 bytes per beat), each input beat becomes two output beats, bits 63:0 first and then bits 127:64, carrying strobe bits 7:0 and 15:8 respectively. The output size code is 3, the output start address is the input address with bits 3:0 cleared, and the output holds twice as many beats as the input.
- R3: In the two-beat expansion, an output half whose eight strobe bits are all zero is still issued.
- R4: Merging applies when all of these hold: size code 2, cache bit 1 = 1, `mergeOff` = 0, an even beat count, and address bits 2:0 = 0. Each input beat is first folded to 64 bits. Each pair of folded beats then forms one output beat: for each byte, the second beat's byte is taken where its strobe is set and the first beat's byte otherwise, and the output strobes are the OR of both. The output has size code 3, the same address, and half as many beats.
- R5: A transaction with a size code below 3 that does not meet the merge condition (for example cache bit 1 = 0, or `mergeOff` = 1) keeps its size, address and beat count. Each beat is folded to 64 bits: if any of strobe bits 15:8 is set, the output takes data bits 127:64 and strobes 15:8; otherwise it takes data bits 63:0 and strobes 7:0.
- R6: When an expansion yields more than 256 output beats, it is issued as bursts of 256 beats followed by the remainder. Each burst's address is 2048 above the previous one, and `mWLast` marks the last beat of every burst.
- R7: The downstream lock bit equals the upstream lock bit when the transaction is issued as one burst, and is 0 when it is split.
- R8: A split transaction returns exactly one upstream response, after the last downstream response. That response is the most severe of the pieces' responses, where DECERR (3) ranks above SLVERR (2), which ranks above OKAY (0).
- R9: For a single-burst transaction, the upstream response equals the downstream response, EXOKAY (1) included.
- R10: Any pattern of valid/ready stalls on either side leaves the delivered beats, addresses and responses unchanged, and a stalled output keeps its payload stable.
- R11: From the acceptance of an address until its response handshake, `sAwReady` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mergeOff | input | 1 | Turns off two-to-one merging |
| sAwAddr | input | ADDR_W | Upstream start address |
| sAwLen | input | LEN_W | Upstream beat count minus one |
| sAwSize | input | 3 | Upstream bytes per beat, as log2 |
| sAwLock | input | 1 | Upstream exclusive-access request |
| sAwCache | input | 4 | Upstream cache attributes; bit 1 = modifiable |
| sAwValid | input | 1 | Upstream address valid |
| sAwReady | output | 1 | Upstream address ready |
| sWData | input | IN_W | Upstream write data |
| sWStrb | input | IN_W/8 | Upstream byte strobes |
| sWValid | input | 1 | Upstream data valid |
| sWReady | output | 1 | Upstream data ready |
| sBResp | output | 2 | Upstream combined response |
| sBValid | output | 1 | Upstream response valid |
| sBReady | input | 1 | Upstream response ready |
| mAwAddr | output | ADDR_W | Downstream burst address |
| mAwLen | output | LEN_W | Downstream beat count minus one |
| mAwSize | output | 3 | Downstream bytes per beat, as log2 |
| mAwLock | output | 1 | Downstream exclusive-access request |
| mAwCache | output | 4 | Downstream cache attributes |
| mAwValid | output | 1 | Downstream address valid |
| mAwReady | input | 1 | Downstream address ready |
| mWData | output | IN_W/2 | Downstream write data |
| mWStrb | output | IN_W/16 | Downstream byte strobes |
| mWLast | output | 1 | Last beat of the downstream burst |
| mWValid | output | 1 | Downstream data valid |
| mWReady | input | 1 | Downstream data ready |
| mBResp | input | 2 | Downstream response |
| mBValid | input | 1 | Downstream response valid |
| mBReady | output | 1 | Downstream response ready |

## Verification
A downstream address is due on the cycle after the upstream address is accepted. Output data beats follow their input beat in the same cycle: directly for expansion and pass-through, and with the second beat of each pair when merging. The upstream response is raised on the cycle after the last downstream response is taken. Since stalls make these offsets drift, the bench records every handshake at the falling edge, where all values are settled. It then compares the recorded sequence of addresses, beats and responses, in order, against values computed from the requirements once the upstream response arrives. The stall behaviour and the timing of the last-beat flag are also watched cycle by cycle by the bound properties.

// File: rtl/dsz_pkg.sv
`timescale 1ns/1ps
package dsz_pkg;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_EXPAND = 2'd1,
    MODE_MERGE  = 2'd2
  } xferModeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch upstream command
    logic pieceStep;  // downstream address accepted, move to next piece address
    logic holdLoad;   // park the first beat of a merge pair
    logic sendUpper;  // expansion: present the upper half
  } dpStrobeT;

  localparam logic [1:0] RESP_OKAY   = 2'd0;
  localparam logic [1:0] RESP_EXOKAY = 2'd1;
  localparam logic [1:0] RESP_SLVERR = 2'd2;
  localparam logic [1:0] RESP_DECERR = 2'd3;

  function automatic logic [1:0] respRank(input logic [1:0] r);
    case (r)
      RESP_DECERR: return 2'd2;
      RESP_SLVERR: return 2'd1;
      default:     return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] respWorse(input logic [1:0] a, input logic [1:0] b);
    return (respRank(b) > respRank(a)) ? b : a;
  endfunction

endpackage

// File: rtl/dsz_ctrl.sv
`timescale 1ns/1ps
module dsz_ctrl
  import dsz_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int CNT_W     = LEN_W + 2,
  parameter int MAX_PIECE = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sAwValid,
  output logic             sAwReady,
  input  logic             sWValid,
  output logic             sWReady,
  output logic [1:0]       sBResp,
  output logic             sBValid,
  input  logic             sBReady,
  output logic             mAwValid,
  input  logic             mAwReady,
  output logic [LEN_W-1:0] mAwLen,
  output logic             mWValid,
  input  logic             mWReady,
  output logic             mWLast,
  input  logic [1:0]       mBResp,
  input  logic             mBValid,
  output logic             mBReady,
  input  xferModeT         mode,
  input  logic [CNT_W-1:0] newTotBeats,
  output dpStrobeT         strobe
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_RESP, ST_REPLY} stateT;

  stateT            state;
  logic [CNT_W-1:0] remaining;
  logic [LEN_W-1:0] outCnt;
  logic [LEN_W-1:0] pieceLen;
  logic             halfSel;
  logic             holdFull;
  logic             firstResp;
  logic [1:0]       accResp;
  logic             wFire;

  assign pieceLen = (remaining > CNT_W'(MAX_PIECE)) ? LEN_W'(MAX_PIECE - 1)
                                                    : LEN_W'(remaining - CNT_W'(1));
  assign sAwReady = (state == ST_IDLE);
  assign mAwValid = (state == ST_ADDR);
  assign mAwLen   = pieceLen;
  assign mWLast   = (state == ST_DATA) && (outCnt == pieceLen);
  assign mBReady  = (state == ST_RESP);
  assign sBValid  = (state == ST_REPLY);
  assign sBResp   = accResp;
  assign wFire    = mWValid && mWReady;

  always_comb begin
    strobe           = '0;
    strobe.capture   = (state == ST_IDLE) && sAwValid;
    strobe.pieceStep = (state == ST_ADDR) && mAwReady;
    strobe.sendUpper = halfSel;
    mWValid          = 1'b0;
    sWReady          = 1'b0;
    if (state == ST_DATA) begin
      case (mode)
        MODE_EXPAND: begin
          mWValid = sWValid;
          sWReady = halfSel && mWReady;
        end
        MODE_MERGE: begin
          mWValid         = sWValid && holdFull;
          sWReady         = holdFull ? mWReady : 1'b1;
          strobe.holdLoad = !holdFull && sWValid;
        end
        default: begin
          mWValid = sWValid;
          sWReady = mWReady;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      outCnt    <= '0;
      halfSel   <= 1'b0;
      holdFull  <= 1'b0;
      firstResp <= 1'b0;
      accResp   <= RESP_OKAY;
    end else begin
      case (state)
        ST_IDLE: if (strobe.capture) begin
          remaining <= newTotBeats;
          outCnt    <= '0;
          halfSel   <= 1'b0;
          holdFull  <= 1'b0;
          firstResp <= 1'b1;
          state     <= ST_ADDR;
        end
        ST_ADDR: if (mAwReady) state <= ST_DATA;
        ST_DATA: begin
          if (strobe.holdLoad) holdFull <= 1'b1;
          if (wFire) begin
            if (mode == MODE_EXPAND) halfSel <= !halfSel;
            if (mode == MODE_MERGE) holdFull <= 1'b0;
            if (mWLast) begin
              outCnt    <= '0;
              remaining <= remaining - CNT_W'(pieceLen) - CNT_W'(1);
              state     <= ST_RESP;
            end else begin
              outCnt <= outCnt + LEN_W'(1);
            end
          end
        end
        ST_RESP: if (mBValid) begin
          accResp   <= firstResp ? mBResp : respWorse(accResp, mBResp);
          firstResp <= 1'b0;
          state     <= (remaining == '0) ? ST_REPLY : ST_ADDR;
        end
        ST_REPLY: if (sBReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dsz_datapath.sv
`timescale 1ns/1ps
module dsz_datapath
  import dsz_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IN_W      = 128,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = LEN_W + 2,
  parameter int MAX_PIECE = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobeT             strobe,
  input  logic                 mergeOff,
  input  logic [ADDR_W-1:0]    sAwAddr,
  input  logic [LEN_W-1:0]     sAwLen,
  input  logic [2:0]           sAwSize,
  input  logic                 sAwLock,
  input  logic [3:0]           sAwCache,
  input  logic [IN_W-1:0]      sWData,
  input  logic [IN_W/8-1:0]    sWStrb,
  output xferModeT             mode,
  output logic [CNT_W-1:0]     newTotBeats,
  output logic [ADDR_W-1:0]    mAwAddr,
  output logic [2:0]           mAwSize,
  output logic                 mAwLock,
  output logic [3:0]           mAwCache,
  output logic [IN_W/2-1:0]    mWData,
  output logic [IN_W/16-1:0]   mWStrb
);

  localparam int OUT_W       = IN_W / 2;
  localparam int IN_BYTES    = IN_W / 8;
  localparam int OUT_BYTES   = OUT_W / 8;
  localparam int IN_SIZE     = $clog2(IN_BYTES);
  localparam int OUT_SIZE    = $clog2(OUT_BYTES);
  localparam int PIECE_BYTES = MAX_PIECE * OUT_BYTES;

  xferModeT         newMode;
  logic [CNT_W-1:0] lenPlus;
  logic             upperHit;
  logic [OUT_W-1:0] foldData, holdData, mergeData;
  logic [OUT_BYTES-1:0] foldStrb, holdStrb;

  // Command decode
  always_comb begin
    lenPlus = CNT_W'(sAwLen) + CNT_W'(1);
    if (sAwSize >= 3'(OUT_SIZE)) begin
      newMode     = MODE_EXPAND;
      newTotBeats = lenPlus << 1;
    end else if (sAwSize == 3'(OUT_SIZE - 1) && sAwCache[1] && !mergeOff &&
                 sAwLen[0] && (sAwAddr[OUT_SIZE-1:0] == '0)) begin
      newMode     = MODE_MERGE;
      newTotBeats = lenPlus >> 1;
    end else begin
      newMode     = MODE_PASS;
      newTotBeats = lenPlus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_PASS;
      mAwAddr  <= '0;
      mAwSize  <= '0;
      mAwLock  <= 1'b0;
      mAwCache <= '0;
    end else if (strobe.capture) begin
      mode     <= newMode;
      mAwAddr  <= (newMode == MODE_EXPAND) ? {sAwAddr[ADDR_W-1:IN_SIZE], IN_SIZE'(0)} : sAwAddr;
      mAwSize  <= (newMode == MODE_PASS) ? sAwSize : 3'(OUT_SIZE);
      mAwLock  <= sAwLock && (newTotBeats <= CNT_W'(MAX_PIECE));
      mAwCache <= sAwCache;
    end else if (strobe.pieceStep) begin
      mAwAddr  <= mAwAddr + ADDR_W'(PIECE_BYTES);
    end
  end

  // Fold a wide beat onto the half that carries its bytes
  assign upperHit = |sWStrb[IN_BYTES-1:OUT_BYTES];
  assign foldData = upperHit ? sWData[IN_W-1:OUT_W] : sWData[OUT_W-1:0];
  assign foldStrb = upperHit ? sWStrb[IN_BYTES-1:OUT_BYTES] : sWStrb[OUT_BYTES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
      holdStrb <= '0;
    end else if (strobe.holdLoad) begin
      holdData <= foldData;
      holdStrb <= foldStrb;
    end
  end

  for (genvar b = 0; b < OUT_BYTES; b++) begin : g_mergeByte
    assign mergeData[b*8 +: 8] = foldStrb[b] ? foldData[b*8 +: 8] : holdData[b*8 +: 8];
  end

  always_comb begin
    case (mode)
      MODE_EXPAND: begin
        mWData = strobe.sendUpper ? sWData[IN_W-1:OUT_W] : sWData[OUT_W-1:0];
        mWStrb = strobe.sendUpper ? sWStrb[IN_BYTES-1:OUT_BYTES] : sWStrb[OUT_BYTES-1:0];
      end
      MODE_MERGE: begin
        mWData = mergeData;
        mWStrb = foldStrb | holdStrb;
      end
      default: begin
        mWData = foldData;
        mWStrb = foldStrb;
      end
    endcase
  end

endmodule

// File: rtl/dsz_top.sv
`timescale 1ns/1ps
module dsz_top
  import dsz_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IN_W      = 128,
  parameter int LEN_W     = 8,
  parameter int MAX_PIECE = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mergeOff,
  input  logic [ADDR_W-1:0]   sAwAddr,
  input  logic [LEN_W-1:0]    sAwLen,
  input  logic [2:0]          sAwSize,
  input  logic                sAwLock,
  input  logic [3:0]          sAwCache,
  input  logic                sAwValid,
  output logic                sAwReady,
  input  logic [IN_W-1:0]     sWData,
  input  logic [IN_W/8-1:0]   sWStrb,
  input  logic                sWValid,
  output logic                sWReady,
  output logic [1:0]          sBResp,
  output logic                sBValid,
  input  logic                sBReady,
  output logic [ADDR_W-1:0]   mAwAddr,
  output logic [LEN_W-1:0]    mAwLen,
  output logic [2:0]          mAwSize,
  output logic                mAwLock,
  output logic [3:0]          mAwCache,
  output logic                mAwValid,
  input  logic                mAwReady,
  output logic [IN_W/2-1:0]   mWData,
  output logic [IN_W/16-1:0]  mWStrb,
  output logic                mWLast,
  output logic                mWValid,
  input  logic                mWReady,
  input  logic [1:0]          mBResp,
  input  logic                mBValid,
  output logic                mBReady
);

  localparam int CNT_W = LEN_W + 2;

  dpStrobeT         strobe;
  xferModeT         mode;
  logic [CNT_W-1:0] newTotBeats;

  dsz_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_PIECE(MAX_PIECE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sAwValid(sAwValid), .sAwReady(sAwReady),
    .sWValid(sWValid), .sWReady(sWReady),
    .sBResp(sBResp), .sBValid(sBValid), .sBReady(sBReady),
    .mAwValid(mAwValid), .mAwReady(mAwReady), .mAwLen(mAwLen),
    .mWValid(mWValid), .mWReady(mWReady), .mWLast(mWLast),
    .mBResp(mBResp), .mBValid(mBValid), .mBReady(mBReady),
    .mode(mode), .newTotBeats(newTotBeats), .strobe(strobe)
  );

  dsz_datapath #(.ADDR_W(ADDR_W), .IN_W(IN_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
                 .MAX_PIECE(MAX_PIECE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mergeOff(mergeOff),
    .sAwAddr(sAwAddr), .sAwLen(sAwLen), .sAwSize(sAwSize), .sAwLock(sAwLock),
    .sAwCache(sAwCache), .sWData(sWData), .sWStrb(sWStrb),
    .mode(mode), .newTotBeats(newTotBeats),
    .mAwAddr(mAwAddr), .mAwSize(mAwSize), .mAwLock(mAwLock), .mAwCache(mAwCache),
    .mWData(mWData), .mWStrb(mWStrb)
  );

endmodule

// File: rtl/dsz_chk.sv
`timescale 1ns/1ps
module dsz_chk #(
  parameter int ADDR_W = 32,
  parameter int IN_W   = 128,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sAwReady,
  input logic              sBValid,
  input logic              sBReady,
  input logic [1:0]        sBResp,
  input logic [ADDR_W-1:0] mAwAddr,
  input logic [LEN_W-1:0]  mAwLen,
  input logic [2:0]        mAwSize,
  input logic              mAwValid,
  input logic              mAwReady,
  input logic [IN_W/2-1:0] mWData,
  input logic [IN_W/16-1:0] mWStrb,
  input logic              mWLast,
  input logic              mWValid,
  input logic              mWReady
);

  localparam int OUT_SIZE = $clog2(IN_W / 16);

  logic [LEN_W-1:0] beatCnt;
  logic [LEN_W-1:0] lenCap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      lenCap  <= '0;
    end else begin
      if (mAwValid && mAwReady) begin
        lenCap  <= mAwLen;
        beatCnt <= '0;
      end else if (mWValid && mWReady) begin
        beatCnt <= mWLast ? '0 : beatCnt + LEN_W'(1);
      end
    end
  end

  // R6: last flag exactly on the announced beat count
  p_last_at_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mWValid && mWLast) |-> (beatCnt == lenCap));
  p_not_last_early_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mWValid && !mWLast) |-> (beatCnt < lenCap));

  // R10: stalled outputs keep valid and payload
  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mAwValid && !mAwReady) |=> (mAwValid && $stable(mAwAddr) && $stable(mAwLen) && $stable(mAwSize)));
  p_w_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mWValid && !mWReady) |=> (mWValid && $stable(mWData) && $stable(mWStrb) && $stable(mWLast)));

  // R8: upstream response held until taken
  p_b_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sBValid && !sBReady) |=> (sBValid && $stable(sBResp)));

  // R11: no new address while a transaction is in flight
  p_single_txn_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sBValid || mAwValid || mWValid) |-> !sAwReady);

  // R2: downstream beat size never exceeds the narrow bus
  p_size_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    mAwValid |-> (mAwSize <= 3'(OUT_SIZE)));

endmodule

bind dsz_top dsz_chk #(.ADDR_W(ADDR_W), .IN_W(IN_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .sAwReady(sAwReady), .sBValid(sBValid), .sBReady(sBReady),
  .sBResp(sBResp), .mAwAddr(mAwAddr), .mAwLen(mAwLen), .mAwSize(mAwSize),
  .mAwValid(mAwValid), .mAwReady(mAwReady), .mWData(mWData), .mWStrb(mWStrb),
  .mWLast(mWLast), .mWValid(mWValid), .mWReady(mWReady)
);

// File: tb/dsz_top_tb.sv
`timescale 1ns/1ps
module dsz_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic         mergeOff;
  logic [31:0]  sAwAddr;
  logic [7:0]   sAwLen;
  logic [2:0]   sAwSize;
  logic         sAwLock;
  logic [3:0]   sAwCache;
  logic         sAwValid, sAwReady;
  logic [127:0] sWData;
  logic [15:0]  sWStrb;
  logic         sWValid, sWReady;
  logic [1:0]   sBResp;
  logic         sBValid, sBReady;
  logic [31:0]  mAwAddr;
  logic [7:0]   mAwLen;
  logic [2:0]   mAwSize;
  logic         mAwLock;
  logic [3:0]   mAwCache;
  logic         mAwValid, mAwReady;
  logic [63:0]  mWData;
  logic [7:0]   mWStrb;
  logic         mWLast, mWValid, mWReady;
  logic [1:0]   mBResp;
  logic         mBValid, mBReady;

  dsz_top u_dut (
    .clk(clk), .rstN(rstN), .mergeOff(mergeOff),
    .sAwAddr(sAwAddr), .sAwLen(sAwLen), .sAwSize(sAwSize), .sAwLock(sAwLock),
    .sAwCache(sAwCache), .sAwValid(sAwValid), .sAwReady(sAwReady),
    .sWData(sWData), .sWStrb(sWStrb), .sWValid(sWValid), .sWReady(sWReady),
    .sBResp(sBResp), .sBValid(sBValid), .sBReady(sBReady),
    .mAwAddr(mAwAddr), .mAwLen(mAwLen), .mAwSize(mAwSize), .mAwLock(mAwLock),
    .mAwCache(mAwCache), .mAwValid(mAwValid), .mAwReady(mAwReady),
    .mWData(mWData), .mWStrb(mWStrb), .mWLast(mWLast), .mWValid(mWValid),
    .mWReady(mWReady), .mBResp(mBResp), .mBValid(mBValid), .mBReady(mBReady)
  );

  int checks = 0;
  int fails  = 0;

  logic [127:0] inData [256];
  logic [15:0]  inStrb [256];
  logic [72:0]  gotBeat [600];
  int           gotN, awN, pendingB, rIdx;
  logic [1:0]   rList [4];
  logic [47:0]  gotAw [4];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] worse(input logic [1:0] a, input logic [1:0] b);
    int ra, rb;
    ra = (a == 2'd3) ? 2 : (a == 2'd2) ? 1 : 0;
    rb = (b == 2'd3) ? 2 : (b == 2'd2) ? 1 : 0;
    return (rb > ra) ? b : a;
  endfunction

  function automatic logic [71:0] foldBeat(input logic [127:0] d, input logic [15:0] s);
    if (|s[15:8]) return {s[15:8], d[127:64]};
    return {s[7:0], d[63:0]};
  endfunction

  // Downstream responder: random readies, responses in order
  initial begin
    mAwReady = 1'b0; mWReady = 1'b0; mBValid = 1'b0; mBResp = 2'd0; pendingB = 0;
    forever begin
      bit bHs;
      @(negedge clk);
      if (mAwValid && mAwReady) begin
        if (awN < 4) gotAw[awN] = {mAwCache, mAwLock, mAwSize, mAwLen, mAwAddr};
        awN++;
      end
      if (mWValid && mWReady) begin
        if (gotN < 600) gotBeat[gotN] = {mWLast, mWStrb, mWData};
        gotN++;
        if (mWLast) pendingB++;
      end
      bHs = mBValid && mBReady;
      @(posedge clk); #1;
      if (bHs) mBValid = 1'b0;
      mAwReady = ($urandom % 3) != 0;
      mWReady  = ($urandom % 4) != 0;
      if (!mBValid && pendingB > 0 && ($urandom % 2) == 1) begin
        mBValid = 1'b1;
        mBResp  = rList[rIdx % 4];
        rIdx++;
        pendingB--;
      end
    end
  end

  task automatic fillBeats(input logic [31:0] addr, input logic [2:0] size, input int n, input bit zeroUpper);
    for (int i = 0; i < n; i++) begin
      inData[i] = {$urandom, $urandom, $urandom, $urandom};
      if (size >= 3) begin
        inStrb[i] = 16'($urandom);
        if (zeroUpper && (i % 2 == 1)) inStrb[i][15:8] = 8'h00;
        if (zeroUpper && (i % 2 == 0)) inStrb[i][7:0]  = 8'h00;
      end else begin
        int bytes, off;
        bytes = 1 << size;
        off   = (int'(addr) + i * bytes) & 15;
        inStrb[i] = 16'($urandom) & 16'(((1 << bytes) - 1) << off);
      end
    end
  endtask

  task automatic runTxn(input logic [31:0] addr, input logic [7:0] len, input logic [2:0] size,
                        input logic lock, input logic [3:0] cache, input logic mOff, input string name);
    bit hs, first;
    logic [1:0] gotResp, expResp;
    int md, n, tot, pieces;
    gotN = 0; awN = 0; rIdx = 0;
    mergeOff = mOff;
    sAwAddr = addr; sAwLen = len; sAwSize = size; sAwLock = lock; sAwCache = cache;
    sAwValid = 1'b1;
    do begin @(negedge clk); hs = sAwReady; @(posedge clk); #1; end while (!hs);
    sAwValid = 1'b0;
    n = int'(len) + 1;
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
      sWValid = 1'b1; sWData = inData[i]; sWStrb = inStrb[i];
      do begin @(negedge clk); hs = sWReady; @(posedge clk); #1; end while (!hs);
      sWValid = 1'b0;
    end
    first = 1'b1;
    do begin
      sBReady = ($urandom % 2) == 1;
      @(negedge clk);
      if (first) begin
        chk(!sAwReady, {"R11 address blocked in flight ", name}, 128'(sAwReady), 128'(0));
        first = 1'b0;
      end
      hs = sBValid && sBReady;
      gotResp = sBResp;
      @(posedge clk); #1;
    end while (!hs);
    sBReady = 1'b0;

    // Expected values
    if (size >= 3) md = 1;
    else if (size == 2 && cache[1] && !mOff && len[0] && addr[2:0] == 3'd0) md = 2;
    else md = 0;
    tot = (md == 1) ? 2 * n : (md == 2) ? n / 2 : n;
    pieces = (tot + 255) / 256;
    chk(awN == pieces, {"R6 piece count ", name}, 128'(awN), 128'(pieces));
    for (int p = 0; p < pieces && p < 4; p++) begin
      logic [31:0] eAddr; logic [7:0] eLen; logic [2:0] eSize; logic eLock;
      int left;
      left  = tot - 256 * p;
      eAddr = ((md == 1) ? {addr[31:4], 4'h0} : addr) + 32'(2048 * p);
      eLen  = 8'(((left > 256) ? 256 : left) - 1);
      eSize = (md == 0) ? size : 3'd3;
      eLock = lock && (pieces == 1);
      chk(gotAw[p] == {cache, eLock, eSize, eLen, eAddr},
          $sformatf("R2/R6/R7 address piece %0d %s", p, name), 128'(gotAw[p]),
          128'({cache, eLock, eSize, eLen, eAddr}));
    end
    chk(gotN == tot, {"R2/R4/R5 beat count ", name}, 128'(gotN), 128'(tot));
    for (int k = 0; k < tot && k < gotN && k < 600; k++) begin
      logic [71:0] e, a, b;
      logic eLast;
      if (md == 1) begin
        int i; i = k / 2;
        e = (k % 2 == 0) ? {inStrb[i][7:0], inData[i][63:0]} : {inStrb[i][15:8], inData[i][127:64]};
      end else if (md == 2) begin
        a = foldBeat(inData[2*k], inStrb[2*k]);
        b = foldBeat(inData[2*k+1], inStrb[2*k+1]);
        for (int j = 0; j < 8; j++) e[j*8 +: 8] = b[64+j] ? b[j*8 +: 8] : a[j*8 +: 8];
        e[71:64] = a[71:64] | b[71:64];
      end else begin
        e = foldBeat(inData[k], inStrb[k]);
      end
      eLast = (k % 256 == 255) || (k == tot - 1);
      chk(gotBeat[k] == {eLast, e},
          $sformatf("%s beat %0d %s", (md == 1) ? "R2/R3/R6" : (md == 2) ? "R4/R10" : "R5/R10", k, name),
          128'(gotBeat[k]), 128'({eLast, e}));
    end
    expResp = rList[0];
    for (int p = 1; p < pieces; p++) expResp = worse(expResp, rList[p]);
    chk(gotResp == expResp, {(pieces > 1) ? "R8 combined response " : "R9 passed response ", name},
        128'(gotResp), 128'(expResp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a001));
    mergeOff = 1'b0; sAwAddr = '0; sAwLen = '0; sAwSize = '0; sAwLock = 1'b0; sAwCache = '0;
    sAwValid = 1'b0; sWData = '0; sWStrb = '0; sWValid = 1'b0; sBReady = 1'b0;
    rList[0] = 2'd0; rList[1] = 2'd0; rList[2] = 2'd0; rList[3] = 2'd0;
    gotN = 0; awN = 0; rIdx = 0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(sAwReady == 1'b1, "R1 address ready after reset", 128'(sAwReady), 128'(1));
    chk(mAwValid == 1'b0, "R1 no downstream address", 128'(mAwValid), 128'(0));
    chk(mWValid == 1'b0, "R1 no downstream data", 128'(mWValid), 128'(0));
    chk(sBValid == 1'b0, "R1 no upstream response", 128'(sBValid), 128'(0));
    @(posedge clk); #1;

    fillBeats(32'h1000, 3'd4, 4, 1'b0);
    runTxn(32'h1000, 8'd3, 3'd4, 1'b0, 4'b0011, 1'b0, "R2 full beats");
    fillBeats(32'h2008, 3'd4, 2, 1'b1);
    runTxn(32'h2008, 8'd1, 3'd4, 1'b0, 4'b0011, 1'b0, "R3 empty halves");
    fillBeats(32'h3000, 3'd3, 3, 1'b0);
    runTxn(32'h3000, 8'd2, 3'd3, 1'b0, 4'b0000, 1'b0, "R2 eight byte beats");
    fillBeats(32'h4000, 3'd2, 8, 1'b0);
    runTxn(32'h4000, 8'd7, 3'd2, 1'b0, 4'b0010, 1'b0, "R4 merge");
    fillBeats(32'h4000, 3'd2, 8, 1'b0);
    runTxn(32'h4000, 8'd7, 3'd2, 1'b0, 4'b0010, 1'b1, "R5 merge switched off");
    fillBeats(32'h4000, 3'd2, 8, 1'b0);
    runTxn(32'h4000, 8'd7, 3'd2, 1'b0, 4'b0000, 1'b0, "R5 not modifiable");
    fillBeats(32'h4000, 3'd2, 3, 1'b0);
    runTxn(32'h4000, 8'd2, 3'd2, 1'b0, 4'b0010, 1'b0, "R5 odd count");
    fillBeats(32'h5003, 3'd0, 5, 1'b0);
    runTxn(32'h5003, 8'd4, 3'd0, 1'b1, 4'b0010, 1'b0, "R5 byte beats");

    rList[0] = 2'd0; rList[1] = 2'd2;
    fillBeats(32'h10000, 3'd4, 200, 1'b0);
    runTxn(32'h10000, 8'd199, 3'd4, 1'b1, 4'b0011, 1'b0, "R6 R7 R8 split slverr");
    rList[0] = 2'd2; rList[1] = 2'd3;
    fillBeats(32'h20000, 3'd4, 256, 1'b0);
    runTxn(32'h20000, 8'd255, 3'd4, 1'b0, 4'b0011, 1'b0, "R8 split decerr");
    rList[0] = 2'd3; rList[1] = 2'd0;
    fillBeats(32'h30000, 3'd4, 130, 1'b0);
    runTxn(32'h30000, 8'd129, 3'd4, 1'b1, 4'b0011, 1'b0, "R8 decerr first");
    rList[0] = 2'd1;
    fillBeats(32'h6000, 3'd4, 128, 1'b0);
    runTxn(32'h6000, 8'd127, 3'd4, 1'b1, 4'b0011, 1'b0, "R7 R9 exclusive kept");

    for (int t = 0; t < 30; t++) begin
      logic [2:0] size; logic [31:0] addr; logic [7:0] len; bit big;
      size = 3'($urandom % 5);
      addr = ($urandom & 32'h000F_FFF0) | (32'($urandom % 16) & ~((32'd1 << size) - 32'd1));
      big  = ($urandom % 8) == 0;
      len  = big ? 8'(128 + $urandom % 128) : 8'($urandom % 16);
      for (int r = 0; r < 4; r++) begin
        rList[r] = 2'($urandom % 4);
        if (size >= 3 && len >= 8'd128 && rList[r] == 2'd1) rList[r] = 2'd0;
      end
      fillBeats(addr, size, int'(len) + 1, 1'b0);
      runTxn(addr, len, size, 1'($urandom % 3 == 0), 4'($urandom % 16), 1'($urandom % 4 == 0),
             $sformatf("R10 random %0d", t));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule